// File: doc/BRIEF.md
# Pass/Fail Speech Clip Player for a Serial DAC

This block plays a short spoken message once a test run has finished. A single request pulse, qualified by a pass/fail flag, chooses one of two clips held in a shared sample memory. Each clip is described by a start address and a sample count, and both are fixed by parameters. The block then fetches the clip's samples in address order, one per sample period.

Each stored sample is an 8-bit unsigned mono value, and the clip rate is nominally 8000 samples per second. The block widens each sample to a 12-bit DAC code and wraps it in a 16-bit command word. A small serial transmitter sends that word to a 12-bit SPI DAC using chip select, serial clock and data. While a clip plays, the block reports busy and ignores any new request. When the last sample of the clip has been shifted out, the block returns to idle.

Top module: `clip_player`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sck` is 0, `busy` is 0 and `mem_rd` is 0.
- R2: A request sampled with `pass_result` = 1 plays the clip at `PASS_BASE` of length `PASS_LEN`. A request sampled with `pass_result` = 0 plays the clip at `FAIL_BASE` of length `FAIL_LEN`.
- R3: A clip reads the addresses base, base+1, … up to base+length−1, each exactly once. It sends exactly one DAC frame per sample and stops after the final sample.
- R4: A frame's 16 bits are, MSB first: bits 15..12 = 0011 (channel A, unbuffered, 1x gain, output active), then bits 11..0 = the sample shifted left by 4. For example, 0xFF gives 0xFF0 and 0x00 gives 0x000.
- R5: `dac_sck` idles low and toggles only while `dac_cs_n` is low. Each frame has exactly 16 rising edges of `dac_sck`. `dac_mosi` changes only while `dac_sck` is low, so it is stable at every rising edge.
- R6: Within a clip, successive frames begin (falling edge of `dac_cs_n`) exactly CLK_HZ/SAMPLE_HZ clock cycles apart.
- R7: A request that arrives while `busy` is 1 is ignored. The clip in progress continues unchanged, and no extra clip follows it.
- R8: `busy` rises in the cycle after an accepted request and stays high until the last frame's chip select has risen. While `busy` is 0, no frame is sent and no memory read occurs.
- R9: The block issues each memory read as a one-cycle `mem_rd` pulse. Read data is taken one cycle later. The first read occurs in the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| play_req | input | 1 | One-cycle request to play a clip |
| pass_result | input | 1 | 1 selects the pass clip, 0 selects the fail clip |
| mem_rd | output | 1 | Sample memory read strobe |
| mem_addr | output | AW | Sample memory address |
| mem_data | input | 8 | Read data, valid the cycle after `mem_rd` |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_sck | output | 1 | DAC serial clock |
| dac_mosi | output | 1 | DAC serial data |
| busy | output | 1 | High while a clip is playing |

## Verification
The hardest case to reach is a second request that lands in the middle of a clip, while the serializer is still shifting or the sample timer is counting down. If such a request were wrongly accepted, it would reload the address or count and change which samples are read. The bench requests the pass clip and then, several hundred cycles in, raises further requests with the fail flag. It then checks that the full read-address trace and frame count still belong only to the pass clip. Back-to-back clips are also driven, so the memory image includes the extreme sample values at clip starts to test the widening.

// File: rtl/clip_player_pkg.sv
package clip_player_pkg;

    localparam int DESC_W = 16;
    localparam logic [3:0] DAC_CMD = 4'b0011;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_LOAD,
        SQ_SEND,
        SQ_HOLD
    } seq_state_t;

    typedef struct packed {
        logic [DESC_W-1:0] base;
        logic [DESC_W-1:0] count;
    } clip_desc_t;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [11:0] code;
    } dac_word_t;

    function automatic logic [11:0] widen_sample(input logic [7:0] s);
        return {s, 4'h0};
    endfunction

    function automatic dac_word_t make_word(input logic [11:0] c);
        dac_word_t w;
        w.cmd  = DAC_CMD;
        w.code = c;
        return w;
    endfunction

endpackage

// File: rtl/clip_select.sv
module clip_select
    import clip_player_pkg::*;
#(
    parameter int unsigned PASS_BASE = 0,
    parameter int unsigned PASS_LEN  = 2400,
    parameter int unsigned FAIL_BASE = 2400,
    parameter int unsigned FAIL_LEN  = 2400
) (
    input  logic       pass_sel,
    output clip_desc_t desc
);
    localparam clip_desc_t PASS_DESC = '{base: DESC_W'(PASS_BASE), count: DESC_W'(PASS_LEN)};
    localparam clip_desc_t FAIL_DESC = '{base: DESC_W'(FAIL_BASE), count: DESC_W'(FAIL_LEN)};

    always_comb begin
        desc = pass_sel ? PASS_DESC : FAIL_DESC;
    end
endmodule

// File: rtl/clip_sample_timer.sv
module clip_sample_timer #(
    parameter int unsigned PERIOD = 15625
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/clip_sequencer.sv
module clip_sequencer
    import clip_player_pkg::*;
#(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          play_req,
    input  clip_desc_t    desc,
    input  logic          tick,
    input  logic          tx_done,
    input  logic [7:0]    mem_data,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          tx_start,
    output dac_word_t     tx_word,
    output logic          busy,
    output logic          restart
);
    localparam int CW = AW + 1;

    seq_state_t    state;
    logic [AW-1:0] addr;
    logic [CW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            addr      <= '0;
            remaining <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (play_req) begin
                        addr      <= desc.base[AW-1:0];
                        remaining <= desc.count[CW-1:0];
                        state     <= SQ_FETCH;
                    end
                end
                SQ_FETCH: state <= SQ_LOAD;
                SQ_LOAD: begin
                    addr      <= addr + 1'b1;
                    remaining <= remaining - 1'b1;
                    state     <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (tx_done) begin
                        state <= (remaining == '0) ? SQ_IDLE : SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (tick) state <= SQ_FETCH;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd   = (state == SQ_FETCH);
        mem_addr = addr;
        tx_start = (state == SQ_LOAD);
        tx_word  = make_word(widen_sample(mem_data));
        busy     = (state != SQ_IDLE);
        restart  = (state == SQ_IDLE) && play_req;
    end
endmodule

// File: rtl/clip_dac_serializer.sv
module clip_dac_serializer
    import clip_player_pkg::*;
#(
    parameter int unsigned HALF = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  dac_word_t word,
    output logic      cs_n,
    output logic      sck,
    output logic      mosi,
    output logic      done
);
    localparam int FW    = $bits(dac_word_t);
    localparam int EDGES = 2 * FW;
    localparam int EW    = $clog2(EDGES);
    localparam int HW    = (HALF > 1) ? $clog2(HALF) : 1;

    logic          active;
    logic [FW-1:0] sreg;
    logic [EW-1:0] edge_i;
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            sck    <= 1'b0;
            sreg   <= '0;
            edge_i <= '0;
            hcnt   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cs_n   <= 1'b0;
                    sck    <= 1'b0;
                    sreg   <= word;
                    edge_i <= '0;
                    hcnt   <= '0;
                end
            end else if (hcnt == HW'(HALF - 1)) begin
                hcnt <= '0;
                if (edge_i == EW'(EDGES - 1)) begin
                    active <= 1'b0;
                    cs_n   <= 1'b1;
                    sck    <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    sck <= ~sck;
                    if (sck) sreg <= {sreg[FW-2:0], 1'b0};
                    edge_i <= edge_i + 1'b1;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign mosi = sreg[FW-1];
endmodule

// File: rtl/clip_player.sv
module clip_player
    import clip_player_pkg::*;
#(
    parameter int unsigned AW        = 13,
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned SAMPLE_HZ = 8000,
    parameter int unsigned SCK_HALF  = 4,
    parameter int unsigned PASS_BASE = 0,
    parameter int unsigned PASS_LEN  = 2400,
    parameter int unsigned FAIL_BASE = 2400,
    parameter int unsigned FAIL_LEN  = 2400
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          play_req,
    input  logic          pass_result,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_data,
    output logic          dac_cs_n,
    output logic          dac_sck,
    output logic          dac_mosi,
    output logic          busy
);
    localparam int unsigned TICKS = CLK_HZ / SAMPLE_HZ;

    clip_desc_t desc;
    dac_word_t  tx_word;
    logic       tick, restart, tx_start, tx_done;

    clip_select #(
        .PASS_BASE(PASS_BASE), .PASS_LEN(PASS_LEN),
        .FAIL_BASE(FAIL_BASE), .FAIL_LEN(FAIL_LEN)
    ) u_sel (
        .pass_sel(pass_result),
        .desc    (desc)
    );

    clip_sample_timer #(.PERIOD(TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (tick)
    );

    clip_sequencer #(.AW(AW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .play_req(play_req),
        .desc    (desc),
        .tick    (tick),
        .tx_done (tx_done),
        .mem_data(mem_data),
        .mem_rd  (mem_rd),
        .mem_addr(mem_addr),
        .tx_start(tx_start),
        .tx_word (tx_word),
        .busy    (busy),
        .restart (restart)
    );

    clip_dac_serializer #(.HALF(SCK_HALF)) u_ser (
        .clk  (clk),
        .rst  (rst),
        .start(tx_start),
        .word (tx_word),
        .cs_n (dac_cs_n),
        .sck  (dac_sck),
        .mosi (dac_mosi),
        .done (tx_done)
    );
endmodule

// File: rtl/clip_player_checker.sv
module clip_player_checker #(
    parameter int unsigned AW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          play_req,
    input logic          busy,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          dac_cs_n,
    input logic          dac_sck,
    input logic          dac_mosi
);
    logic [AW-1:0] prev_addr;
    logic          have_prev;
    logic          cs_q, sck_q;
    logic [5:0]    rise_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (mem_rd) begin
            have_prev <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q     <= 1'b1;
            sck_q    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            cs_q  <= dac_cs_n;
            sck_q <= dac_sck;
            if (cs_q && !dac_cs_n) rise_cnt <= '0;
            else if (dac_sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_cs_n && !mem_rd)); // R8
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (play_req && !busy) |=> busy); // R8
    AST_SCK_FRAMED: assert property (@(posedge clk) disable iff (rst)
        dac_cs_n |-> !dac_sck); // R5
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        dac_sck |-> $stable(dac_mosi)); // R5
    AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (rst)
        (dac_cs_n && !cs_q) |-> (rise_cnt == 6'd16)); // R5
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd); // R9
    AST_FIRST_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_rd); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && have_prev) |-> (mem_addr == AW'(prev_addr + 1'b1))); // R3
endmodule

bind clip_player clip_player_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .play_req(play_req),
    .busy    (busy),
    .mem_rd  (mem_rd),
    .mem_addr(mem_addr),
    .dac_cs_n(dac_cs_n),
    .dac_sck (dac_sck),
    .dac_mosi(dac_mosi)
);

// File: tb/clip_player_tb.sv
module clip_player_tb;
    localparam int AW        = 8;
    localparam int CLK_HZ    = 125_000_000;
    localparam int SAMPLE_HZ = 625_000;
    localparam int TICKS     = CLK_HZ / SAMPLE_HZ;
    localparam int PASS_BASE = 16;
    localparam int PASS_LEN  = 5;
    localparam int FAIL_BASE = 100;
    localparam int FAIL_LEN  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          play_req = 1'b0;
    logic          pass_result = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data = 8'h00;
    logic          dac_cs_n, dac_sck, dac_mosi, busy;

    always #4 clk = ~clk;

    clip_player #(
        .AW(AW), .CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .SCK_HALF(2),
        .PASS_BASE(PASS_BASE), .PASS_LEN(PASS_LEN),
        .FAIL_BASE(FAIL_BASE), .FAIL_LEN(FAIL_LEN)
    ) u_dut (
        .clk(clk), .rst(rst), .play_req(play_req), .pass_result(pass_result),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .dac_cs_n(dac_cs_n), .dac_sck(dac_sck), .dac_mosi(dac_mosi), .busy(busy)
    );

    function automatic logic [7:0] model(input int a);
        if (a == PASS_BASE) return 8'hFF;
        if (a == FAIL_BASE) return 8'h00;
        return 8'((a * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_data <= model(int'(mem_addr));
    end

    int          nchk = 0, nfail = 0;
    int          cyc = 0;
    int          nf = 0, nr = 0;
    int          fstart [64];
    logic [15:0] fword [64];
    int          fbits [64];
    logic        fbusy [64];
    int          raddr [64];
    int          busy_rise_cyc = -1;
    logic [15:0] sh = '0;
    int          nb = 0;
    logic        cs_p = 1'b1, sck_p = 1'b0, busy_p = 1'b0;
    int          req_cyc = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (dac_sck && !sck_p && !dac_cs_n) begin
            sh = {sh[14:0], dac_mosi};
            nb = nb + 1;
        end
        if (!dac_cs_n && cs_p && nf < 64) begin
            fstart[nf] = cyc + 1;
            sh = '0;
            nb = 0;
        end
        if (dac_cs_n && !cs_p && nf < 64) begin
            fword[nf] = sh;
            fbits[nf] = nb;
            fbusy[nf] = busy;
            nf = nf + 1;
        end
        if (mem_rd && nr < 64) begin
            raddr[nr] = int'(mem_addr);
            nr = nr + 1;
        end
        if (busy && !busy_p) busy_rise_cyc = cyc + 1;
        cs_p   = dac_cs_n;
        sck_p  = dac_sck;
        busy_p = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic request(input logic pass);
        @(negedge clk);
        #1;
        play_req    = 1'b1;
        pass_result = pass;
        req_cyc     = cyc;
        @(negedge clk);
        #1;
        play_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic verify_clip(input int f0, input int r0, input int base, input int len,
                               input int rq, input string tag);
        chk(busy_rise_cyc == rq + 1, "R8 busy rises one cycle after request", busy_rise_cyc, rq + 1);
        chk(nf - f0 == len, {"R3 frame count ", tag}, nf - f0, len);
        chk(nr - r0 == len, {"R9 read count ", tag}, nr - r0, len);
        for (int i = 0; i < len && (f0 + i) < nf && (r0 + i) < nr; i++) begin
            chk(raddr[r0 + i] == base + i, {"R2 R3 read address ", tag}, raddr[r0 + i], base + i);
            chk(fword[f0 + i][15:12] == 4'b0011, {"R4 command nibble ", tag},
                int'(fword[f0 + i][15:12]), 3);
            chk(fword[f0 + i][11:0] == {model(base + i), 4'h0}, {"R4 data code ", tag},
                int'(fword[f0 + i][11:0]), int'({model(base + i), 4'h0}));
            chk(fbits[f0 + i] == 16, {"R5 rising edges per frame ", tag}, fbits[f0 + i], 16);
            if (i > 0)
                chk(fstart[f0 + i] - fstart[f0 + i - 1] == TICKS, {"R6 frame spacing ", tag},
                    fstart[f0 + i] - fstart[f0 + i - 1], TICKS);
        end
        if (nf > f0) chk(fbusy[nf - 1] == 1'b1, {"R8 busy held through last frame ", tag},
                         int'(fbusy[nf - 1]), 1);
        chk(busy == 1'b0 && dac_cs_n == 1'b1, {"R8 idle after clip ", tag},
            int'({busy, dac_cs_n}), 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(dac_cs_n == 1'b1, "R1 cs_n in reset", int'(dac_cs_n), 1);
        chk(dac_sck == 1'b0, "R1 sck in reset", int'(dac_sck), 0);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(mem_rd == 1'b0, "R1 mem_rd in reset", int'(mem_rd), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && dac_cs_n == 1'b1, "R1 idle after reset", int'({busy, dac_cs_n}), 1);
    endtask

    task automatic t_pass_clip();
        int f0 = nf, r0 = nr;
        request(1'b1);
        wait_idle();
        verify_clip(f0, r0, PASS_BASE, PASS_LEN, req_cyc, "pass");
        chk(fword[f0] == 16'h3FF0, "R4 sample 0xFF widens to 0xFF0", int'(fword[f0]), 16'h3FF0);
    endtask

    task automatic t_fail_clip();
        int f0 = nf, r0 = nr;
        request(1'b0);
        wait_idle();
        verify_clip(f0, r0, FAIL_BASE, FAIL_LEN, req_cyc, "fail");
        chk(fword[f0] == 16'h3000, "R4 sample 0x00 widens to 0x000", int'(fword[f0]), 16'h3000);
    endtask

    task automatic t_ignore_busy();
        int f0 = nf, r0 = nr, rq;
        request(1'b1);
        rq = req_cyc;
        repeat (TICKS + 50) @(negedge clk);
        request(1'b0);
        repeat (TICKS) @(negedge clk);
        request(1'b0);
        wait_idle();
        verify_clip(f0, r0, PASS_BASE, PASS_LEN, rq, "R7 request during playback");
        repeat (TICKS * 3) @(negedge clk);
        chk(nf - f0 == PASS_LEN, "R7 no extra clip after ignored request", nf - f0, PASS_LEN);
    endtask

    task automatic t_idle_quiet();
        int f0 = nf, r0 = nr;
        repeat (TICKS * 4) @(negedge clk);
        chk(nf == f0, "R8 no frames while idle", nf - f0, 0);
        chk(nr == r0, "R8 no reads while idle", nr - r0, 0);
    endtask

    task automatic t_back_to_back();
        int f0, r0;
        request(1'b0);
        wait_idle();
        f0 = nf;
        r0 = nr;
        request(1'b1);
        wait_idle();
        verify_clip(f0, r0, PASS_BASE, PASS_LEN, req_cyc, "R2 pass right after fail");
    endtask

    initial begin
        t_reset();
        t_pass_clip();
        t_fail_clip();
        t_ignore_busy();
        t_idle_quiet();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog R8: actual %0d cycles expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end
endmodule